// File: doc/BRIEF.md
# Interleaved Two-Channel Ramp PWM

This block is a single up-counting timer that feeds two PWM outputs by taking turns. Counter cycles alternate between an A cycle and a B cycle. Channel 0 may be active only during A cycles and channel 1 only during B cycles, so the two waveforms never drive their active level at the same time. With equal periods, each channel repeats once every two counter cycles, and its highest possible duty is half of that combined period.

The period, an optional second period used in B cycles, and the two compare values all come in as plain ports. They act as buffers: the working copies are refreshed only at the end of a B cycle, so new settings reach both channels together and a change made mid-cycle cannot cut a pulse short. A tick enable paces the counter from an outside divider. Each channel has its own polarity control. A global enable parks the timer at the start of an A cycle with both outputs inactive. At a 1 MHz tick and a period of 9999, each channel runs at 50 Hz.

Top module: `ilv_pwm`

## Requirements
- R1: While enabled, the counter advances by one on each clock with `tick` high, wraps to 0 after it equals the current period, and holds on clocks with `tick` low. From enable with `tick` held high, the first A cycle therefore lasts period+1 clocks.
- R2: Each wrap toggles the cycle phase. `phase_b` is 0 in A cycles and 1 in B cycles.
- R3: Channel 0 (`wave[0]`) can be active only in A cycles and channel 1 (`wave[1]`) only in B cycles, so both are never active together.
- R4: In its own cycle, a channel is active while the count is below its compare value and inactive for the rest of the cycle. A compare value above the period gives an active level for the whole cycle; a compare value of 0 never gives an active level.
- R5: With `alt_en` set, A cycles use `per_a` and B cycles use `per_b`. With `alt_en` clear, both cycles use `per_a` and `per_b` has no effect.
- R6: `per_a`, `per_b`, `alt_en`, `cmp0`, and `cmp1` take effect only at the wrap that ends a B cycle, and apply to both channels together. A value presented in the same clock as that wrap is taken.
- R7: Bit i of `pol` sets the inactive level of `wave[i]`. The active level is its inverse, so `pol[i]`=0 means active-high.
- R8: Outputs are registered. `wave` reflects the counter state one clock later.
- R9: While `en` is low, the counter is 0, the phase is A, both outputs sit at their inactive level from the next clock onward, and the buffered inputs are copied into the working registers on every clock.
- R10: A synchronous active-high `rst` gives the same state as disable: count 0, phase A, outputs inactive, and the buffers loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global enable |
| tick | input | 1 | Count enable, one clock per counter step |
| per_a | input | CNT_W | Primary period (buffered) |
| per_b | input | CNT_W | Secondary period for B cycles (buffered) |
| alt_en | input | 1 | Use `per_b` in B cycles (buffered) |
| cmp0 | input | CNT_W | Channel 0 compare (buffered) |
| cmp1 | input | CNT_W | Channel 1 compare (buffered) |
| pol | input | 2 | Per-channel inactive level |
| wave | output | 2 | PWM outputs, bit 0 is channel 0 |
| phase_b | output | 1 | High during B cycles |

## Verification
The buffer copy at the end of a B cycle can coincide with new values arriving on the compare and period ports. The same edge can also carry the phase toggle, or a drop of the enable. The bench finds the end of a B cycle by watching `phase_b`. It then presents a new period and compare in exactly the clock of that wrap and checks that the next A cycle already runs with the new length. Separately, a compare is changed in the middle of an A cycle and checked to leave that pair's pulse width unchanged. A cycle-accurate model, written in the bench from the requirements, is compared against both outputs on every clock during these collisions.

// File: rtl/ilv_pwm_pkg.sv
package ilv_pwm_pkg;
  localparam int NCH = 2;
  typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} phase_t;
endpackage

// File: rtl/ilv_pwm_timebase.sv
module ilv_pwm_timebase
  import ilv_pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] per_a,
  input  logic [W-1:0] per_b,
  input  logic         alt,
  output logic [W-1:0] cnt,
  output phase_t       phase,
  output logic         load
);
  logic [W-1:0] top_val;
  logic         at_top;

  assign top_val = (phase == PH_B && alt) ? per_b : per_a;
  assign at_top  = (cnt == top_val);
  // working copies refresh while idle or on the wrap that closes a B cycle
  assign load    = !en || (tick && at_top && phase == PH_B);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      phase <= PH_A;
    end else if (tick) begin
      if (at_top) begin
        cnt   <= '0;
        phase <= (phase == PH_A) ? PH_B : PH_A;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= top_val);
  p_hold_no_tick_r1: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> ($stable(cnt) && $stable(phase)));
  p_wrap_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    (en && tick && at_top) |=> (cnt == '0 && phase != $past(phase)));
  p_idle_parked_r9: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> (cnt == '0 && phase == PH_A));
endmodule

// File: rtl/ilv_pwm_shadow.sv
module ilv_pwm_shadow
  import ilv_pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [W-1:0]           per_a_in,
  input  logic [W-1:0]           per_b_in,
  input  logic                   alt_in,
  input  logic [NCH-1:0][W-1:0]  cmp_in,
  output logic [W-1:0]           per_a,
  output logic [W-1:0]           per_b,
  output logic                   alt,
  output logic [NCH-1:0][W-1:0]  cmp
);
  always_ff @(posedge clk) begin
    if (rst || load) begin
      per_a <= per_a_in;
      per_b <= per_b_in;
      alt   <= alt_in;
      for (int i = 0; i < NCH; i++) cmp[i] <= cmp_in[i];
    end
  end

  p_update_at_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> ($stable(per_a) && $stable(per_b) && $stable(alt) && $stable(cmp)));
endmodule

// File: rtl/ilv_pwm_chan.sv
module ilv_pwm_chan
  import ilv_pwm_pkg::*;
#(
  parameter int     W   = 16,
  parameter phase_t OWN = PH_A
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         pol,
  input  logic [W-1:0] cnt,
  input  phase_t       phase,
  input  logic [W-1:0] cmp,
  output logic         wave
);
  logic live;

  assign live = en && (phase == OWN) && (cnt < cmp);

  always_ff @(posedge clk) begin
    if (rst) wave <= pol;
    else     wave <= pol ^ live;
  end

  p_own_phase_only_r3: assert property (@(posedge clk) disable iff (rst)
    (wave != $past(pol)) |-> ($past(phase) == OWN && $past(en)));
endmodule

// File: rtl/ilv_pwm.sv
module ilv_pwm
  import ilv_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] per_a,
  input  logic [CNT_W-1:0] per_b,
  input  logic             alt_en,
  input  logic [CNT_W-1:0] cmp0,
  input  logic [CNT_W-1:0] cmp1,
  input  logic [1:0]       pol,
  output logic [1:0]       wave,
  output logic             phase_b
);
  logic [NCH-1:0][CNT_W-1:0] cmp_buf, cmp_act;
  logic [CNT_W-1:0]          per_a_act, per_b_act, cnt;
  logic                      alt_act, load;
  phase_t                    phase;

  assign cmp_buf[0] = cmp0;
  assign cmp_buf[1] = cmp1;
  assign phase_b    = (phase == PH_B);

  ilv_pwm_shadow #(.W(CNT_W)) u_shadow (
    .clk(clk), .rst(rst), .load(load),
    .per_a_in(per_a), .per_b_in(per_b), .alt_in(alt_en), .cmp_in(cmp_buf),
    .per_a(per_a_act), .per_b(per_b_act), .alt(alt_act), .cmp(cmp_act)
  );

  ilv_pwm_timebase #(.W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .en(en), .tick(tick),
    .per_a(per_a_act), .per_b(per_b_act), .alt(alt_act),
    .cnt(cnt), .phase(phase), .load(load)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ilv_pwm_chan #(.W(CNT_W), .OWN(i == 0 ? PH_A : PH_B)) u_ch (
      .clk(clk), .rst(rst), .en(en), .pol(pol[i]),
      .cnt(cnt), .phase(phase), .cmp(cmp_act[i]), .wave(wave[i])
    );
  end

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wave ^ $past(pol)));
  p_off_inactive_r9: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> (wave == $past(pol)));
endmodule

// File: tb/tb_ilv_pwm.sv
`timescale 1ns/1ps
module tb_ilv_pwm;
  localparam int W = 16;

  logic clk = 0, rst = 1, en = 0, tick = 1, alt_en = 0;
  logic [W-1:0] per_a = 9, per_b = 9, cmp0 = 0, cmp1 = 0;
  logic [1:0] pol = 2'b10;
  logic [1:0] wave;
  logic phase_b;

  int total = 0, bad = 0;
  bit chk_on = 0, done = 0;
  string tag = "R4";

  always #5 clk = ~clk;

  ilv_pwm #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .per_a(per_a), .per_b(per_b),
    .alt_en(alt_en), .cmp0(cmp0), .cmp1(cmp1), .pol(pol),
    .wave(wave), .phase_b(phase_b)
  );

  // reference model built from the requirements
  int m_cnt, m_pa, m_pb, m_c0, m_c1;
  bit m_ph, m_alt;
  logic [1:0] m_wave;
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_ph = 0; m_wave = pol;
      m_pa = per_a; m_pb = per_b; m_alt = alt_en; m_c0 = cmp0; m_c1 = cmp1;
    end else begin
      automatic bit a0 = en && !m_ph && (m_cnt < m_c0);
      automatic bit a1 = en && m_ph && (m_cnt < m_c1);
      automatic int cur = (m_ph && m_alt) ? m_pb : m_pa;
      automatic bit wrap = (m_cnt == cur);
      automatic bit ld = !en || (tick && m_ph && wrap);
      if (!en) begin m_cnt = 0; m_ph = 0; end
      else if (tick) begin
        if (wrap) begin m_cnt = 0; m_ph = !m_ph; end
        else m_cnt = m_cnt + 1;
      end
      if (ld) begin
        m_pa = per_a; m_pb = per_b; m_alt = alt_en; m_c0 = cmp0; m_c1 = cmp1;
      end
      m_wave = pol ^ {a1, a0};
    end
  end

  always @(posedge clk) begin
    #2;
    if (chk_on && !done) begin
      total++;
      if (wave !== m_wave) begin
        bad++;
        $display("FAIL %s R4 R8 wave actual=%b expected=%b", tag, wave, m_wave);
      end
      total++;
      if (phase_b !== m_ph) begin
        bad++;
        $display("FAIL %s R2 phase_b actual=%b expected=%b", tag, phase_b, m_ph);
      end
      total++;
      if ((wave ^ pol) == 2'b11) begin
        bad++;
        $display("FAIL R3 overlap actual=%b expected=not both active", wave ^ pol);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_fall_b();
    @(negedge clk);
    while (phase_b !== 1'b1) @(negedge clk);
    while (phase_b !== 1'b0) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  typedef struct packed {
    logic [15:0] pa; logic [15:0] pb; logic alt;
    logic [15:0] c0; logic [15:0] c1; logic [1:0] pl;
    int len; int e0; int e1;
  } row_t;

  // expected active clocks per channel over one A+B pair
  localparam row_t TBL [6] = '{
    '{16'd9, 16'd9,  1'b0, 16'd5,  16'd5, 2'b00, 20, 5,  5},
    '{16'd9, 16'd9,  1'b0, 16'd10, 16'd0, 2'b01, 20, 10, 0},
    '{16'd7, 16'd3,  1'b1, 16'd3,  16'd4, 2'b10, 12, 3,  4},
    '{16'd4, 16'd11, 1'b1, 16'd20, 16'd6, 2'b11, 17, 5,  6},
    '{16'd0, 16'd0,  1'b0, 16'd1,  16'd1, 2'b00, 2,  1,  1},
    '{16'd5, 16'd2,  1'b0, 16'd3,  16'd6, 2'b00, 12, 3,  6}
  };

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    int n, a0, a1;
    // R10: reset state
    cyc(3);
    check("R10 wave after reset", wave, 2'b10);
    check("R10 phase_b after reset", phase_b, 0);
    rst = 0;
    chk_on = 1;
    cyc(2);
    check("R9 wave idle inactive", wave, 2'b10);

    // table of configurations: duty per channel over one pair
    foreach (TBL[k]) begin
      en = 0;
      per_a = TBL[k].pa; per_b = TBL[k].pb; alt_en = TBL[k].alt;
      cmp0 = TBL[k].c0; cmp1 = TBL[k].c1; pol = TBL[k].pl; tick = 1;
      tag = "R5";
      cyc(2);
      en = 1;
      cyc(2 * TBL[k].len + 3);
      a0 = 0; a1 = 0;
      for (int j = 0; j < TBL[k].len; j++) begin
        @(negedge clk);
        if (wave[0] != pol[0]) a0++;
        if (wave[1] != pol[1]) a1++;
      end
      check($sformatf("R4 R5 R7 row%0d ch0 active", k), a0, TBL[k].e0);
      check($sformatf("R4 R5 R7 row%0d ch1 active", k), a1, TBL[k].e1);
    end

    // R1: first A cycle length after enable
    en = 0; per_a = 6; alt_en = 0; cmp0 = 3; cmp1 = 3; pol = 2'b00;
    cyc(2);
    en = 1;
    n = 0;
    @(negedge clk); n++;
    while (phase_b !== 1'b1 && n < 50) begin @(negedge clk); n++; end
    check("R1 first A cycle clocks", n, 7);

    // R1: tick gating, judged by the model
    tag = "R1";
    for (int j = 0; j < 60; j++) begin
      tick = (j % 3) != 0;
      @(negedge clk);
    end
    tick = 1;

    // R9: drop enable mid-cycle
    cyc(3);
    en = 0;
    @(negedge clk);
    check("R9 wave on disable", wave, 2'b00);
    check("R9 phase_b on disable", phase_b, 0);
    en = 1;

    // R6: mid-A compare write leaves current pair alone
    tag = "R6";
    per_a = 9; cmp0 = 4; cmp1 = 4; pol = 2'b00;
    en = 0; cyc(2); en = 1;
    wait_fall_b();
    a0 = 0;
    for (int j = 1; j <= 20; j++) begin
      @(negedge clk);
      if (j == 2) cmp0 = 9;
      if (wave[0]) a0++;
    end
    check("R6 ch0 pair with mid-cycle write", a0, 4);
    a0 = 0;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      if (wave[0]) a0++;
    end
    check("R6 ch0 pair after boundary", a0, 9);

    // R6: write in the very clock of the end-of-B wrap
    per_a = 5; cmp0 = 2; cmp1 = 2;
    en = 0; cyc(2); en = 1;
    @(negedge clk);
    while (phase_b !== 1'b0) @(negedge clk);
    while (phase_b !== 1'b1) @(negedge clk);
    cyc(5);
    per_a = 3; cmp1 = 3;
    @(negedge clk);
    n = 0;
    while (phase_b === 1'b0 && n < 50) begin n++; @(negedge clk); end
    check("R6 A cycle after same-clock write", n, 4);
    cyc(10);

    // R10: reset while running
    tag = "R10";
    pol = 2'b01;
    cyc(2);
    rst = 1;
    @(negedge clk);
    check("R10 wave on running reset", wave, 2'b01);
    check("R10 phase_b on running reset", phase_b, 0);
    rst = 0;
    cyc(30);
    finish_up();
  end
endmodule